// File: doc/BRIEF.md
# Accumulator Processor Control Sequencer

This block is the control sequencer of a small 16-bit accumulator processor. It holds a 4-bit state register with fourteen defined codes. Each cycle it drives the control points of a datapath that is outside the block: the ALU function, the memory bus operation, the program-counter input mux and increment select, the load enables of the instruction/data latch, the accumulator and the address-out register, the address-out source select and the data-bus drive select. Its only inputs are the opcode field of the latched instruction, the accumulator sign bit and a synchronous reset.

After reset the sequencer runs two setup states and then enters the fetch state. In fetch it issues the instruction read and decodes the opcode into one of six execution paths. Those paths are register operate, single-operand operate, load, store, conditional branch on a negative accumulator, and jump. Every path returns to fetch. The control outputs depend on the current state. In the fetch, register-operate and single-operand states they also depend on the opcode. The next-state and output decode can be built in one of two ways, chosen by a parameter: as gate logic, or as a table indexed by state, opcode and sign bit that is computed at elaboration.

Top module: `acc_ctl_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 0000. In state 0000 the only active output is `pc_sel`=01, and the next state is 0001.
- R2: State 0001 drives `pc_sel`=10, `pc_inc`=1 and `ao_le`=1, and moves to fetch, which is code 0010.
- R3: Fetch drives `pc_sel`=11 and `di_le`=1. If `opcode[4:3]`=00, the next state is chosen by `opcode[2:0]`: 00x goes to 0100, 010 to 1011, 011 to 1101, 100 to 0101, 101 to 1000 and 11x to 0011. In those cases `mem_op` is 01 (read), except for 00x, which gives 00 (idle). An opcode with `opcode[4:3]`≠00 issues no read and goes to the idle code 0111.
- R4: In 0011, `opcode[0]`=0 gives `alu_op`=010 (AND) and 1 gives 011 (ADD). In 0100, `opcode[0]`=0 gives 001 (NOT B) and 1 gives 100 (B shifted right). In all four cases `ac_le`=1, `ao_le`=1, `pc_sel`=10 and `pc_inc`=1, and the next state is fetch.
- R5: The load path is 1000, then 1001, then 1010, then fetch. 1000 drives `pc_sel`=11, `ao_sel`=1 and `ao_le`=1. 1001 drives `mem_op`=01, `pc_sel`=11 and `di_le`=1. 1010 drives `ac_le`=1, `ao_le`=1, `pc_sel`=10 and `pc_inc`=1.
- R6: The store path is 0101, then 0110, then 0111, then fetch. 0101 has the same outputs as 1000. 0110 drives `mem_op`=10 (write), `edb_sel`=1, `pc_sel`=10, `pc_inc`=1 and `ao_le`=1. In 0111 all outputs are zero.
- R7: State 1011 drives `pc_sel`=10, `pc_inc`=1 and `ao_le`=1. It goes to 1100 when `ac_sign`=1 and to fetch when `ac_sign`=0.
- R8: States 1100 and 1101 drive `pc_sel`=10, `pc_inc`=0, `ao_sel`=1 and `ao_le`=1, and go to fetch.
- R9: The table variant (`USE_ROM`=1) produces the same state sequence and outputs as the gate-logic variant for every input sequence.
- R10: Outputs with no role in a state are driven to 0. `alu_op` is 000 outside 0011 and 0100. `edb_sel` is 0 outside 0110. `di_le` and `ac_le` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OPC_W (5) | Opcode field of the latched instruction |
| ac_sign | input | 1 | Accumulator sign bit |
| alu_op | output | 3 | ALU function code |
| mem_op | output | 2 | Memory bus operation: 00 idle, 01 read, 10 write |
| pc_sel | output | 2 | Program-counter input mux select |
| pc_inc | output | 1 | Program-counter increment select |
| di_le | output | 1 | Instruction/data latch load enable |
| ac_le | output | 1 | Accumulator load enable |
| ao_sel | output | 1 | Address-out source select |
| ao_le | output | 1 | Address-out register load enable |
| edb_sel | output | 1 | Data-bus drive select |
| state_o | output | 4 | Current state code |

## Verification
A synchronous reset can arrive in the same cycle as a decision the sequencer is making for itself. That decision can be the opcode branch out of fetch or the sign test out of 1011. The reset must win, while the outputs of that cycle still show the state that was current. The bench provokes this in two ways. It asserts reset on purpose when the sequencer is in fetch with a branch opcode and when it is in 1011 with the sign bit set, and random reset pulses land on every other state. It judges each case by whether the next state is 0000 and not the branch target.

// File: rtl/acc_ctl_pkg.sv
`timescale 1ns/1ps
package acc_ctl_pkg;

  localparam int ST_W  = 4;
  localparam int OPL_W = 3;

  // State codes; the datapath sequencing depends on these exact values.
  localparam logic [ST_W-1:0] ST_RST1  = 4'd0;
  localparam logic [ST_W-1:0] ST_RST2  = 4'd1;
  localparam logic [ST_W-1:0] ST_FETCH = 4'd2;
  localparam logic [ST_W-1:0] ST_AOPR  = 4'd3;
  localparam logic [ST_W-1:0] ST_SOPR  = 4'd4;
  localparam logic [ST_W-1:0] ST_ST1   = 4'd5;
  localparam logic [ST_W-1:0] ST_ST2   = 4'd6;
  localparam logic [ST_W-1:0] ST_ST3   = 4'd7;
  localparam logic [ST_W-1:0] ST_LD1   = 4'd8;
  localparam logic [ST_W-1:0] ST_LD2   = 4'd9;
  localparam logic [ST_W-1:0] ST_LD3   = 4'd10;
  localparam logic [ST_W-1:0] ST_BR1   = 4'd11;
  localparam logic [ST_W-1:0] ST_BR2   = 4'd12;
  localparam logic [ST_W-1:0] ST_JMP   = 4'd13;

  localparam logic [2:0] ALU_PASS = 3'b000;
  localparam logic [2:0] ALU_NOTB = 3'b001;
  localparam logic [2:0] ALU_AND  = 3'b010;
  localparam logic [2:0] ALU_ADD  = 3'b011;
  localparam logic [2:0] ALU_SHRB = 3'b100;

  localparam logic [1:0] MEM_IDLE = 2'b00;
  localparam logic [1:0] MEM_RD   = 2'b01;
  localparam logic [1:0] MEM_WR   = 2'b10;

  localparam logic [1:0] PCSEL_INIT  = 2'b01;
  localparam logic [1:0] PCSEL_ADV   = 2'b10;
  localparam logic [1:0] PCSEL_FETCH = 2'b11;

  typedef struct packed {
    logic [2:0] alu;
    logic [1:0] mem;
    logic [1:0] pc_sel;
    logic       pc_inc;
    logic       di_le;
    logic       ac_le;
    logic       ao_sel;
    logic       ao_le;
    logic       edb_sel;
  } ctl_word_t;

  localparam int WORD_W = $bits(ctl_word_t);

  // Successor of a state given the opcode low bits, their validity and the sign bit.
  function automatic logic [ST_W-1:0] ctl_next(input logic [ST_W-1:0] st,
                                               input logic vld,
                                               input logic [OPL_W-1:0] op,
                                               input logic sgn);
    logic [ST_W-1:0] n;
    case (st)
      ST_RST1: n = ST_RST2;
      ST_RST2: n = ST_FETCH;
      ST_FETCH: begin
        if (!vld)               n = ST_ST3;
        else if (op[2:1] == 2'b11) n = ST_AOPR;
        else if (op[2:1] == 2'b00) n = ST_SOPR;
        else begin
          case (op[1:0])
            2'b10:   n = ST_BR1;
            2'b11:   n = ST_JMP;
            2'b00:   n = ST_ST1;
            default: n = ST_LD1;
          endcase
        end
      end
      ST_ST1:  n = ST_ST2;
      ST_ST2:  n = ST_ST3;
      ST_LD1:  n = ST_LD2;
      ST_LD2:  n = ST_LD3;
      ST_BR1:  n = sgn ? ST_BR2 : ST_FETCH;
      ST_AOPR, ST_SOPR, ST_ST3, ST_LD3, ST_BR2, ST_JMP: n = ST_FETCH;
      default: n = ST_RST1;
    endcase
    return n;
  endfunction

  // Control-point word of a state; unused fields stay zero.
  function automatic ctl_word_t ctl_word(input logic [ST_W-1:0] st,
                                         input logic vld,
                                         input logic [OPL_W-1:0] op);
    ctl_word_t w;
    w = '0;
    case (st)
      ST_RST1: w.pc_sel = PCSEL_INIT;
      ST_RST2: begin
        w.pc_sel = PCSEL_ADV; w.pc_inc = 1'b1; w.ao_le = 1'b1;
      end
      ST_FETCH: begin
        w.pc_sel = PCSEL_FETCH; w.di_le = 1'b1;
        w.mem    = (vld && op[2:1] != 2'b00) ? MEM_RD : MEM_IDLE;
      end
      ST_AOPR, ST_SOPR: begin
        if (st == ST_AOPR) w.alu = op[0] ? ALU_ADD  : ALU_AND;
        else               w.alu = op[0] ? ALU_SHRB : ALU_NOTB;
        w.ac_le = 1'b1; w.ao_le = 1'b1; w.pc_sel = PCSEL_ADV; w.pc_inc = 1'b1;
      end
      ST_ST1, ST_LD1: begin
        w.pc_sel = PCSEL_FETCH; w.ao_sel = 1'b1; w.ao_le = 1'b1;
      end
      ST_ST2: begin
        w.mem = MEM_WR; w.edb_sel = 1'b1;
        w.pc_sel = PCSEL_ADV; w.pc_inc = 1'b1; w.ao_le = 1'b1;
      end
      ST_LD2: begin
        w.mem = MEM_RD; w.pc_sel = PCSEL_FETCH; w.di_le = 1'b1;
      end
      ST_LD3: begin
        w.ac_le = 1'b1; w.ao_le = 1'b1; w.pc_sel = PCSEL_ADV; w.pc_inc = 1'b1;
      end
      ST_BR1: begin
        w.pc_sel = PCSEL_ADV; w.pc_inc = 1'b1; w.ao_le = 1'b1;
      end
      ST_BR2, ST_JMP: begin
        w.pc_sel = PCSEL_ADV; w.ao_sel = 1'b1; w.ao_le = 1'b1;
      end
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/acc_ctl_state_reg.sv
`timescale 1ns/1ps
module acc_ctl_state_reg #(
  parameter int              W       = 4,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/acc_ctl_decode.sv
`timescale 1ns/1ps
module acc_ctl_decode
  import acc_ctl_pkg::*;
#(
  parameter bit USE_ROM = 1'b0
) (
  input  logic [ST_W-1:0]  st,
  input  logic             vld,
  input  logic [OPL_W-1:0] op,
  input  logic             sgn,
  output logic [ST_W-1:0]  nxt,
  output ctl_word_t        word
);
  localparam int IDX_W = ST_W + 1 + OPL_W + 1;
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = ST_W + WORD_W;

  generate
    if (USE_ROM) begin : g_table
      logic [ENT_W-1:0] rom [DEPTH];
      logic [IDX_W-1:0] idx;
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam logic [IDX_W-1:0] K = IDX_W'(i);
        // index layout: {state, valid, opcode low bits, sign}
        assign rom[i] = {ctl_next(K[IDX_W-1 -: ST_W], K[OPL_W+1], K[OPL_W:1], K[0]),
                         ctl_word(K[IDX_W-1 -: ST_W], K[OPL_W+1], K[OPL_W:1])};
      end
      assign idx  = {st, vld, op, sgn};
      assign nxt  = rom[idx][ENT_W-1 -: ST_W];
      assign word = rom[idx][WORD_W-1:0];
    end else begin : g_logic
      assign nxt  = ctl_next(st, vld, op, sgn);
      assign word = ctl_word(st, vld, op);
    end
  endgenerate
endmodule

// File: rtl/acc_ctl_seq.sv
`timescale 1ns/1ps
module acc_ctl_seq
  import acc_ctl_pkg::*;
#(
  parameter bit USE_ROM = 1'b0,
  parameter int OPC_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             ac_sign,
  output logic [2:0]       alu_op,
  output logic [1:0]       mem_op,
  output logic [1:0]       pc_sel,
  output logic             pc_inc,
  output logic             di_le,
  output logic             ac_le,
  output logic             ao_sel,
  output logic             ao_le,
  output logic             edb_sel,
  output logic [ST_W-1:0]  state_o
);
  logic [ST_W-1:0] state_q;
  logic [ST_W-1:0] state_d;
  logic            opc_valid;
  ctl_word_t       word;

  // Only opcodes with zero upper bits name an instruction.
  assign opc_valid = (opcode[OPC_W-1:OPL_W] == '0);

  acc_ctl_state_reg #(.W(ST_W), .RST_VAL(ST_RST1)) u_state (
    .clk (clk),
    .rst (rst),
    .d   (state_d),
    .q   (state_q)
  );

  acc_ctl_decode #(.USE_ROM(USE_ROM)) u_dec (
    .st   (state_q),
    .vld  (opc_valid),
    .op   (opcode[OPL_W-1:0]),
    .sgn  (ac_sign),
    .nxt  (state_d),
    .word (word)
  );

  assign alu_op  = word.alu;
  assign mem_op  = word.mem;
  assign pc_sel  = word.pc_sel;
  assign pc_inc  = word.pc_inc;
  assign di_le   = word.di_le;
  assign ac_le   = word.ac_le;
  assign ao_sel  = word.ao_sel;
  assign ao_le   = word.ao_le;
  assign edb_sel = word.edb_sel;
  assign state_o = state_q;
endmodule

// File: rtl/acc_ctl_seq_chk.sv
`timescale 1ns/1ps
module acc_ctl_seq_chk
  import acc_ctl_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [ST_W-1:0] state,
  input logic            opc_valid,
  input logic            ac_sign,
  input logic [1:0]      mem_op,
  input logic [1:0]      pc_sel,
  input logic            pc_inc,
  input logic            di_le,
  input logic            ac_le,
  input logic            ao_sel,
  input logic            edb_sel
);
  p_sync_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == ST_RST1) && (pc_sel == PCSEL_INIT));

  p_fetch_ctl_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |-> di_le && (pc_sel == PCSEL_FETCH));

  p_bad_opcode_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && !opc_valid) |=> (state == ST_ST3));

  p_load_chain_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LD1) |=> (state == ST_LD2));

  p_write_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_op == MEM_WR) |-> edb_sel && (state == ST_ST2));

  p_branch_taken_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BR1 && ac_sign) |=> (state == ST_BR2));

  p_redirect_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BR2 || state == ST_JMP) |-> !pc_inc && ao_sel);

  p_loads_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({di_le, ac_le}));
endmodule

bind acc_ctl_seq acc_ctl_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .state     (state_o),
  .opc_valid (opc_valid),
  .ac_sign   (ac_sign),
  .mem_op    (mem_op),
  .pc_sel    (pc_sel),
  .pc_inc    (pc_inc),
  .di_le     (di_le),
  .ac_le     (ac_le),
  .ao_sel    (ao_sel),
  .edb_sel   (edb_sel)
);

// File: tb/acc_ctl_seq_tb.sv
`timescale 1ns/1ps
module acc_ctl_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] opcode = '0;
  logic       ac_sign = 1'b0;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;
  logic [3:0] exp_st = 4'd0;

  logic [2:0] a_alu, b_alu;
  logic [1:0] a_mem, b_mem, a_pcs, b_pcs;
  logic       a_inc, a_di, a_ac, a_aos, a_aol, a_edb;
  logic       b_inc, b_di, b_ac, b_aos, b_aol, b_edb;
  logic [3:0] a_st, b_st;

  always #10 clk = ~clk;

  acc_ctl_seq #(.USE_ROM(1'b0)) u_dut (
    .clk(clk), .rst(rst), .opcode(opcode), .ac_sign(ac_sign),
    .alu_op(a_alu), .mem_op(a_mem), .pc_sel(a_pcs), .pc_inc(a_inc),
    .di_le(a_di), .ac_le(a_ac), .ao_sel(a_aos), .ao_le(a_aol),
    .edb_sel(a_edb), .state_o(a_st));

  acc_ctl_seq #(.USE_ROM(1'b1)) u_dut_rom (
    .clk(clk), .rst(rst), .opcode(opcode), .ac_sign(ac_sign),
    .alu_op(b_alu), .mem_op(b_mem), .pc_sel(b_pcs), .pc_inc(b_inc),
    .di_le(b_di), .ac_le(b_ac), .ao_sel(b_aos), .ao_le(b_aol),
    .edb_sel(b_edb), .state_o(b_st));

  // Expected vector {alu,mem,pc_sel,pc_inc,di,ac,ao_sel,ao_le,edb}, per the requirements.
  function automatic logic [12:0] model_out(input logic [3:0] s, input logic [4:0] o);
    logic rd;
    rd = (o[4:3] == 2'b00) && (o[2:1] != 2'b00);
    case (s)
      4'd0:  return 13'b000_00_01_000000;
      4'd1:  return 13'b000_00_10_100010;
      4'd2:  return {3'b000, rd ? 2'b01 : 2'b00, 8'b11_010000};
      4'd3:  return {o[0] ? 3'b011 : 3'b010, 10'b00_10_101010};
      4'd4:  return {o[0] ? 3'b100 : 3'b001, 10'b00_10_101010};
      4'd5,
      4'd8:  return 13'b000_00_11_000110;
      4'd6:  return 13'b000_10_10_100011;
      4'd9:  return 13'b000_01_11_010000;
      4'd10: return 13'b000_00_10_101010;
      4'd11: return 13'b000_00_10_100010;
      4'd12,
      4'd13: return 13'b000_00_10_000110;
      default: return 13'b0;
    endcase
  endfunction

  function automatic logic [3:0] model_next(input logic [3:0] s, input logic [4:0] o,
                                            input logic g);
    case (s)
      4'd0: return 4'd1;
      4'd1: return 4'd2;
      4'd2: begin
        if (o[4:3] != 2'b00) return 4'd7;
        case (o[2:0])
          3'd0, 3'd1: return 4'd4;
          3'd2:       return 4'd11;
          3'd3:       return 4'd13;
          3'd4:       return 4'd5;
          3'd5:       return 4'd8;
          default:    return 4'd3;
        endcase
      end
      4'd5: return 4'd6;
      4'd6: return 4'd7;
      4'd8: return 4'd9;
      4'd9: return 4'd10;
      4'd11: return g ? 4'd12 : 4'd2;
      default: return 4'd2;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd8, 4'd9, 4'd10: return "R5";
      4'd5, 4'd6, 4'd7: return "R6";
      4'd11: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, compare after settling, advance the model.
  task automatic step(input logic [4:0] o, input logic g, input logic r);
    logic [12:0] ea, eb, ex;
    @(negedge clk);
    opcode = o; ac_sign = g; rst = r;
    #2;
    ex = model_out(exp_st, o);
    ea = {a_alu, a_mem, a_pcs, a_inc, a_di, a_ac, a_aos, a_aol, a_edb};
    eb = {b_alu, b_mem, b_pcs, b_inc, b_di, b_ac, b_aos, b_aol, b_edb};
    chk(a_st == exp_st, req_of(exp_st), "state", 16'(a_st), 16'(exp_st));
    chk(ea == ex, req_of(exp_st), "controls", 16'(ea), 16'(ex));
    chk(b_st == exp_st && eb == ex, "R9", "table variant", 16'({b_st, eb[11:0]}),
        16'({exp_st, ex[11:0]}));
    if (exp_st != 4'd3 && exp_st != 4'd4)
      chk(a_alu == 3'b000, "R10", "idle alu_op", 16'(a_alu), 16'd0);
    if (exp_st != 4'd6)
      chk(a_edb == 1'b0, "R10", "idle edb_sel", 16'(a_edb), 16'd0);
    exp_st = r ? 4'd0 : model_next(exp_st, o, g);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd5150);
    repeat (3) @(negedge clk);
    exp_st = 4'd0;
    step(5'd0, 1'b0, 1'b1);                         // R1 reset state
    // Directed: every opcode under both sign values, each held for a full path.
    for (int op = 0; op < 8; op++) begin
      for (int sg = 0; sg < 2; sg++) begin
        repeat (6) step(5'(op), 1'(sg), 1'b0);
      end
    end
    // R3: upper opcode bits nonzero skip through the idle state.
    repeat (6) step(5'b11010, 1'b1, 1'b0);
    repeat (6) step(5'b01101, 1'b0, 1'b0);
    // Reset colliding with a fetch decode and with a taken branch decision (R1, R7).
    step(5'd2, 1'b1, 1'b1);
    repeat (2) step(5'd2, 1'b1, 1'b0);            // RST1 -> RST2 -> FETCH
    step(5'd2, 1'b1, 1'b1);                        // reset in fetch wins over brn1
    repeat (3) step(5'd2, 1'b1, 1'b0);            // RST1, RST2, FETCH -> BR1
    step(5'd2, 1'b1, 1'b1);                        // reset in BR1 wins over BR2
    repeat (8) step(5'd2, 1'b1, 1'b0);
    // Constrained random.
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] o;
      o = 5'($urandom_range(0, 7));
      if ($urandom_range(0, 7) == 0) o[4:3] = 2'($urandom_range(1, 3));
      step(o, 1'($urandom_range(0, 1)), ($urandom_range(0, 63) == 0));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule